// File: doc/BRIEF.md
# Thread Yield Qualifier

This unit judges a yield request made by the running hardware thread context. It takes a signed yield operand and a qualifier mask, and it returns a single-cycle `done` pulse. With the pulse come three results: a deactivate strobe that clears the caller's own activated flag, a fault flag with a 3-bit exception code for the VPE control register, and the operand ANDed with the mask.

The operand is decoded three ways.

- **Zero operand.** The unit walks the configured contexts one per clock. It looks for a context that is bound to the caller's VPE and context number, is dynamically allocatable, is not halted and is activated. If one is found, the caller is told to deactivate itself.
- **Positive operand.** It faults with code 2 when it shares no bit with the mask.
- **Negative operand.** It faults with code 4 only when the scheduler-intervention control bit and the caller's dirty flag are both set. The value -2 is exempt from this check.

The per-context status is read live from the surrounding context registers while the walk runs. The caller identity is captured when the request is accepted.

Top module: `yield_qualifier`

## Requirements
- R1: After reset, `busy`, `done`, `deactivate` and `fault` are 0, and `exc_code` and `result` are 0.
- R2: A request with a nonzero operand completes with `done` visible right after the accepting clock edge. A zero-operand request completes N edges later, where N = `ctx_count_m1` + 1. During that time `busy` is 1.
- R3: For a zero operand, `deactivate` is 1 on the `done` cycle when some scanned context index i ≤ `ctx_count_m1` meets all of these conditions: its VPE binding equals the caller VPE, its context binding equals the caller context, its allocate bit is 1, its halt bit is 0 and its active bit is 1. A zero operand never faults.
- R4: If any one of those conditions fails, or the only matching context has an index above `ctx_count_m1`, then `deactivate` stays 0.
- R5: A positive operand with (operand AND mask) = 0 gives `fault` = 1 and `exc_code` = 2.
- R6: A positive operand that has at least one bit in common with the mask gives `fault` = 0 and `exc_code` = 0.
- R7: A negative operand (bit 31 set) other than -2 gives `fault` = 1 and `exc_code` = 4 when `sched_intervene` and `caller_dirty` are both 1.
- R8: A negative operand gives no fault and `exc_code` 0 when either of those two bits is 0, or when the operand is exactly -2.
- R9: `result` takes operand AND mask on the `done` cycle and holds that value until the next `done`.
- R10: A request raised while `busy` is 1 is ignored. It causes no `done` of its own and does not change the result of the walk in progress.
- R11: `done` lasts one cycle per request. `fault` and `deactivate` are 0 on every cycle without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Yield request, accepted when not busy |
| yield_src | input | 32 | Signed yield operand (two's complement) |
| yield_mask | input | 32 | Yield qualifier mask |
| caller_vpe | input | 4 | VPE number of the caller |
| caller_ctx | input | 3 | Context number of the caller |
| caller_dirty | input | 1 | Caller's dirty flag |
| sched_intervene | input | 1 | Scheduler-intervention control bit |
| ctx_count_m1 | input | 3 | Number of configured contexts minus one |
| ctx_alloc | input | 8 | Per-context dynamic-allocate bits |
| ctx_halt | input | 8 | Per-context halt bits |
| ctx_active | input | 8 | Per-context activated bits |
| ctx_bind_vpe | input | 32 | Per-context VPE binding, 4 bits per context |
| ctx_bind_ctx | input | 24 | Per-context context binding, 3 bits per context |
| busy | output | 1 | A zero-operand scan is in progress |
| done | output | 1 | One-cycle completion pulse |
| deactivate | output | 1 | Clear the caller's activated bit |
| fault | output | 1 | Thread fault raised |
| exc_code | output | 3 | Exception code: 0 none, 2 mask miss, 4 scheduler |
| result | output | 32 | Operand AND mask |

## Verification
A nonzero operand has its results due on the first falling edge after the accepting rising edge. A zero operand has them due exactly `ctx_count_m1`+1 falling edges later. Each scenario drives the request on a falling edge and counts falling edges until `done` appears, then compares that count with the expected latency before it reads `fault`, `exc_code`, `deactivate` and `result` on the same edge. The falling edge right after each pulse is sampled as well, to confirm that the flags have dropped and `result` has held. In the busy case, the ignored request is checked to raise no pulse on the edge it would have used.

// File: rtl/yq_pkg.sv
package yq_pkg;
   localparam int EXC_W = 3;
   localparam logic [EXC_W-1:0] EXC_NONE  = 3'd0;
   localparam logic [EXC_W-1:0] EXC_MASK  = 3'd2;
   localparam logic [EXC_W-1:0] EXC_SCHED = 3'd4;
endpackage

// File: rtl/yq_ctx_match.sv
module yq_ctx_match #(
   parameter int VPE_W = 4,
   parameter int IDX_W = 3
) (
   input  logic             alloc,
   input  logic             halted,
   input  logic             active,
   input  logic [VPE_W-1:0] bind_vpe,
   input  logic [IDX_W-1:0] bind_ctx,
   input  logic [VPE_W-1:0] want_vpe,
   input  logic [IDX_W-1:0] want_ctx,
   output logic             hit
);
   assign hit = alloc && !halted && active &&
                (bind_vpe == want_vpe) && (bind_ctx == want_ctx);
endmodule

// File: rtl/yq_decode.sv
module yq_decode
   import yq_pkg::*;
#(
   parameter int VAL_W = 32
) (
   input  logic [VAL_W-1:0] src,
   input  logic [VAL_W-1:0] mask,
   input  logic             intervene,
   input  logic             dirty,
   output logic             is_zero,
   output logic             fault,
   output logic [EXC_W-1:0] code
);
   localparam logic [VAL_W-1:0] NEG_TWO = {{(VAL_W-1){1'b1}}, 1'b0};

   logic is_neg;
   logic no_overlap;

   assign is_zero    = (src == '0);
   assign is_neg     = src[VAL_W-1];
   assign no_overlap = ((src & mask) == '0);

   always_comb begin
      fault = 1'b0;
      code  = EXC_NONE;
      if (!is_zero && !is_neg && no_overlap) begin
         fault = 1'b1;
         code  = EXC_MASK;
      end else if (is_neg && (src != NEG_TWO) && intervene && dirty) begin
         fault = 1'b1;
         code  = EXC_SCHED;
      end
   end
endmodule

// File: rtl/yq_scan.sv
module yq_scan #(
   parameter int NUM_CTX = 8,
   localparam int IDX_W = $clog2(NUM_CTX)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [IDX_W-1:0]   last_idx,
   input  logic [NUM_CTX-1:0] hit_vec,
   output logic               busy,
   output logic               finish,
   output logic               found
);
   logic [IDX_W-1:0] idx;
   logic             acc;

   assign finish = busy && (idx == last_idx);
   assign found  = acc | hit_vec[idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         idx  <= '0;
         acc  <= 1'b0;
      end else if (start) begin
         busy <= 1'b1;
         idx  <= '0;
         acc  <= 1'b0;
      end else if (busy) begin
         acc <= found;
         if (idx == last_idx) busy <= 1'b0;
         else                 idx  <= idx + 1'b1;
      end
   end

   // R2
   scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> idx == $past(idx) + 1'b1);
   // R2
   scan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> idx <= last_idx);
endmodule

// File: rtl/yield_qualifier.sv
module yield_qualifier
   import yq_pkg::*;
#(
   parameter int VAL_W   = 32,
   parameter int NUM_CTX = 8,
   parameter int VPE_W   = 4,
   localparam int IDX_W  = $clog2(NUM_CTX)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic [VAL_W-1:0]           yield_src,
   input  logic [VAL_W-1:0]           yield_mask,
   input  logic [VPE_W-1:0]           caller_vpe,
   input  logic [IDX_W-1:0]           caller_ctx,
   input  logic                       caller_dirty,
   input  logic                       sched_intervene,
   input  logic [IDX_W-1:0]           ctx_count_m1,
   input  logic [NUM_CTX-1:0]         ctx_alloc,
   input  logic [NUM_CTX-1:0]         ctx_halt,
   input  logic [NUM_CTX-1:0]         ctx_active,
   input  logic [NUM_CTX*VPE_W-1:0]   ctx_bind_vpe,
   input  logic [NUM_CTX*IDX_W-1:0]   ctx_bind_ctx,
   output logic                       busy,
   output logic                       done,
   output logic                       deactivate,
   output logic                       fault,
   output logic [EXC_W-1:0]           exc_code,
   output logic [VAL_W-1:0]           result
);
   generate
      if (VAL_W < 2) begin : g_bad_w
         $error("VAL_W must be at least 2");
      end
      if (NUM_CTX < 2 || (1 << IDX_W) != NUM_CTX) begin : g_bad_n
         $error("NUM_CTX must be a power of two, at least 2");
      end
   endgenerate

   logic [VAL_W-1:0] src_q, mask_q;
   logic [VPE_W-1:0] vpe_q;
   logic [IDX_W-1:0] ctx_q;
   logic             dec_zero, dec_fault;
   logic [EXC_W-1:0] dec_code;
   logic [NUM_CTX-1:0] hit_vec;
   logic             scan_finish, scan_found, accept;

   assign accept = req_valid && !busy;

   yq_decode #(.VAL_W(VAL_W)) u_dec (
      .src(yield_src), .mask(yield_mask),
      .intervene(sched_intervene), .dirty(caller_dirty),
      .is_zero(dec_zero), .fault(dec_fault), .code(dec_code));

   for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
      yq_ctx_match #(.VPE_W(VPE_W), .IDX_W(IDX_W)) u_match (
         .alloc(ctx_alloc[i]), .halted(ctx_halt[i]), .active(ctx_active[i]),
         .bind_vpe(ctx_bind_vpe[i*VPE_W +: VPE_W]),
         .bind_ctx(ctx_bind_ctx[i*IDX_W +: IDX_W]),
         .want_vpe(vpe_q), .want_ctx(ctx_q), .hit(hit_vec[i]));
   end

   yq_scan #(.NUM_CTX(NUM_CTX)) u_scan (
      .clk(clk), .rst_n(rst_n), .start(accept && dec_zero),
      .last_idx(ctx_count_m1), .hit_vec(hit_vec),
      .busy(busy), .finish(scan_finish), .found(scan_found));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= '0; mask_q <= '0; vpe_q <= '0; ctx_q <= '0;
      end else if (accept) begin
         src_q  <= yield_src;
         mask_q <= yield_mask;
         vpe_q  <= caller_vpe;
         ctx_q  <= caller_ctx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done <= 1'b0; deactivate <= 1'b0; fault <= 1'b0;
         exc_code <= EXC_NONE; result <= '0;
      end else begin
         done <= 1'b0; deactivate <= 1'b0; fault <= 1'b0;
         exc_code <= EXC_NONE;
         if (accept && !dec_zero) begin
            done     <= 1'b1;
            fault    <= dec_fault;
            exc_code <= dec_code;
            result   <= yield_src & yield_mask;
         end else if (scan_finish) begin
            done       <= 1'b1;
            deactivate <= scan_found;
            result     <= src_q & mask_q;
         end
      end
   end

   // R2
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R11
   flags_need_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault || deactivate) |-> done);
   // R5
   fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (exc_code == EXC_MASK || exc_code == EXC_SCHED));
   // R6
   clean_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fault |-> exc_code == EXC_NONE);
   // R3
   deact_nofault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      deactivate |-> !fault);
   // R9
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result));
endmodule

// File: tb/tb_yield_qualifier.sv
module tb_yield_qualifier;
   localparam int CLK_PERIOD = 10;
   localparam int N = 8;

   logic clk = 0, rst_n = 0, req_valid = 0;
   logic [31:0] yield_src = 0, yield_mask = 0;
   logic [3:0]  caller_vpe = 0;
   logic [2:0]  caller_ctx = 0, ctx_count_m1 = 0;
   logic        caller_dirty = 0, sched_intervene = 0;
   logic [N-1:0] ctx_alloc = 0, ctx_halt = 0, ctx_active = 0;
   logic [N*4-1:0] ctx_bind_vpe = 0;
   logic [N*3-1:0] ctx_bind_ctx = 0;
   logic busy, done, deactivate, fault;
   logic [2:0] exc_code;
   logic [31:0] result;
   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   yield_qualifier dut (.*);

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   // all contexts bound to VPE 0, own index, otherwise eligible
   task automatic ctx_base();
      for (int i = 0; i < N; i++) begin
         ctx_bind_vpe[i*4 +: 4] = 4'd0;
         ctx_bind_ctx[i*3 +: 3] = 3'(i);
      end
      ctx_alloc = '1; ctx_halt = '0; ctx_active = '1;
      caller_vpe = 4'd1; caller_ctx = 3'd3;
   endtask

   task automatic issue(logic [31:0] s, logic [31:0] m);
      @(negedge clk);
      yield_src = s; yield_mask = m; req_valid = 1;
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic wait_done(string req, int exp_lat);
      int cnt = 0;
      while (!done && cnt < 40) begin
         @(negedge clk);
         cnt++;
      end
      chk(req, 32'(cnt), 32'(exp_lat));
   endtask

   task automatic t_reset();
      chk("R1 busy", 32'(busy), 0);
      chk("R1 done", 32'(done), 0);
      chk("R1 flags", {30'd0, deactivate, fault}, 0);
      chk("R1 code", 32'(exc_code), 0);
      chk("R1 result", result, 0);
   endtask

   task automatic t_nonzero(string req, logic [31:0] s, logic [31:0] m,
                            logic iv, logic dy, logic f, logic [2:0] c);
      sched_intervene = iv; caller_dirty = dy;
      issue(s, m);
      wait_done({req, " R2 latency"}, 0);
      chk({req, " fault"}, 32'(fault), 32'(f));
      chk({req, " code"}, 32'(exc_code), 32'(c));
      chk({req, " R9 result"}, result, s & m);
      chk({req, " no deact"}, 32'(deactivate), 0);
      @(negedge clk);
      chk({req, " R11 pulse"}, {29'd0, done, fault, deactivate}, 0);
      chk({req, " R9 hold"}, result, s & m);
   endtask

   task automatic t_scan(string req, logic [2:0] cnt_m1, logic exp_deact);
      ctx_count_m1 = cnt_m1;
      issue(32'd0, 32'hFFFF_FFFF);
      chk({req, " R2 busy"}, 32'(busy), 1);
      wait_done({req, " R2 latency"}, int'(cnt_m1) + 1);
      chk({req, " deact"}, 32'(deactivate), 32'(exp_deact));
      chk({req, " R3 nofault"}, 32'(fault), 0);
      chk({req, " R9 result"}, result, 0);
      @(negedge clk);
      chk({req, " R11 pulse"}, {30'd0, done, deactivate}, 0);
   endtask

   task automatic t_busy_ignore();
      ctx_base(); ctx_bind_vpe[3*4 +: 4] = 4'd1; ctx_count_m1 = 3'd5;
      issue(32'd0, 32'h0);
      @(negedge clk);
      yield_src = 32'h5; yield_mask = 32'hA; req_valid = 1;
      @(negedge clk);
      req_valid = 0;
      chk("R10 no extra done", 32'(done), 0);
      chk("R10 still busy", 32'(busy), 1);
      wait_done("R10 latency", 4);
      chk("R10 walk result", 32'(deactivate), 1);
      chk("R10 no fault", 32'(fault), 0);
      chk("R10 result", result, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_nonzero("R6 overlap", 32'h0000_00F0, 32'h0000_0030, 0, 0, 0, 3'd0);
      t_nonzero("R5 miss", 32'h0000_0005, 32'h0000_000A, 1, 1, 1, 3'd2);
      t_nonzero("R5 top", 32'h4000_0000, 32'h3FFF_FFFF, 0, 0, 1, 3'd2);
      t_nonzero("R7 neg", 32'hFFFF_FFFB, 32'h0000_00FF, 1, 1, 1, 3'd4);
      t_nonzero("R7 min", 32'h8000_0000, 32'h0, 1, 1, 1, 3'd4);
      t_nonzero("R8 no dirty", 32'hFFFF_FFFB, 32'hFF, 1, 0, 0, 3'd0);
      t_nonzero("R8 no sched", 32'hFFFF_FFFB, 32'hFF, 0, 1, 0, 3'd0);
      t_nonzero("R8 minus two", 32'hFFFF_FFFE, 32'hFF, 1, 1, 0, 3'd0);
      ctx_base(); ctx_bind_vpe[3*4 +: 4] = 4'd1;
      t_scan("R3 match", 3'd5, 1);
      t_scan("R3 full", 3'd7, 1);
      ctx_base(); ctx_bind_vpe[0 +: 4] = 4'd1; caller_ctx = 3'd0;
      t_scan("R3 single", 3'd0, 1);
      ctx_base(); ctx_bind_vpe[3*4 +: 4] = 4'd1; ctx_alloc[3] = 0;
      t_scan("R4 alloc", 3'd5, 0);
      ctx_base(); ctx_bind_vpe[3*4 +: 4] = 4'd1; ctx_halt[3] = 1;
      t_scan("R4 halt", 3'd5, 0);
      ctx_base(); ctx_bind_vpe[3*4 +: 4] = 4'd1; ctx_active[3] = 0;
      t_scan("R4 active", 3'd5, 0);
      ctx_base(); ctx_bind_vpe[3*4 +: 4] = 4'd1; caller_ctx = 3'd2;
      t_scan("R4 ctx", 3'd5, 0);
      ctx_base(); caller_ctx = 3'd7; ctx_bind_vpe[7*4 +: 4] = 4'd1;
      t_scan("R4 beyond", 3'd5, 0);
      t_busy_ignore();
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule